// File: doc/BRIEF.md
# NAND Flash Host Bridge Registers

This block is a byte-wide register front end through which a host processor drives a raw NAND flash device by software. The host address space is split into 256-byte pages. Page 0 is reserved and inert. Page 1 is a configuration page that holds a window enable and a relocatable 32-bit window base. When the window is enabled, one further page becomes live: the page whose base matches the programmed value. That page exposes the following registers:

- a data port;
- a mode register whose bits drive the NAND control pins directly and carry a two-bit ECC command;
- a constant status byte;
- an interrupt status and mask pair that produces a single interrupt line.

The NAND device and the ECC engine sit outside the block. The block hands them the control pins, an 8-bit output bus with a write strobe, a read strobe with an 8-bit input bus, and a pair of ECC strobes (clear and fetch).

Every register write takes effect at the clock edge that samples it. All outputs come straight from flops. A read returns its byte, together with a one-cycle `acc_rvalid`, on the second edge after the request.

Top module: `nand_host_regs`

## Requirements
- R1: In the configuration page (address bits 31:8 equal to 1), bit 1 of the byte at offset 0x04 sets the window enable. Reading that byte returns 0x02 when the window is enabled and 0x00 when it is not.
- R2: Configuration offsets 0x10, 0x11, 0x12 and 0x13 each load one byte lane of the 32-bit window base, holding bits 7:0, 15:8, 23:16 and 31:24 respectively. Reading one of these offsets returns the lane it selects. After reset the base is zero.
- R3: The window decodes only when the window is enabled and the access address with its low 8 bits forced to zero equals the base. Page 0 and the configuration page never decode as the window. Outside the window, writes change nothing and reads return 0x00.
- R4: The window's mode register is at offset 0x04 and reads back as written. Its bit 0 drives `nand_cle`, bit 1 drives `nand_ale`, bit 7 drives `nand_wp`, and `nand_ce_n` is the inverse of bit 4. After reset all mode bits are 0, so `nand_ce_n` is 1.
- R5: A write to the mode register emits a one-cycle strobe chosen by bits 6:5 of the written byte. The codes 01 and 11 pulse `ecc_clr`, the code 10 pulses `ecc_rd`, and the code 00 pulses neither.
- R6: A write to window offsets 0x00 to 0x03 places the byte on `nand_dout`, pulses `nand_we` for one cycle, and sets bit 0 of interrupt status while leaving its other bits unchanged.
- R7: A read of window offsets 0x00 to 0x03 pulses `nand_re` in the cycle after the request and returns the `nand_din` value sampled at the end of that cycle.
- R8: The window's status byte at offset 0x05 always reads 0x14.
- R9: A write to interrupt status (offset 0x06) replaces its whole value. The interrupt mask (offset 0x07) is written and read as a plain byte. Unmapped window offsets read 0x00.
- R10: `irq` is 1 exactly when mask bit 7 is set and the AND of mask and status is nonzero. It changes at the same edge as the register write that changes either input.
- R11: A read request yields `acc_rvalid` high for one cycle, with `acc_rdata` valid, on the second rising edge after the request is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Access request, sampled each edge |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 32 | Byte address |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data |
| acc_rvalid | output | 1 | Read data valid pulse |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_wp | output | 1 | Write-protect pin level |
| nand_dout | output | 8 | Byte to the NAND I/O bus |
| nand_we | output | 1 | Write strobe for `nand_dout` |
| nand_re | output | 1 | Read strobe |
| nand_din | input | 8 | Byte from the NAND I/O bus |
| ecc_clr | output | 1 | ECC accumulator clear strobe |
| ecc_rd | output | 1 | ECC result fetch strobe |
| irq | output | 1 | Interrupt request |

## Verification
The bench programs a base whose low byte is nonzero and checks that the window stays dead. A decoder that ignores the low byte would instead let a mode write drop `nand_ce_n`. The bench also writes through the window while the enable is off. A design that skips the enable check would move the pins or return register data. Data writes are made on top of a random status value. A design that overwrites status, instead of setting bit 0, would lose the other bits, and one that misses the global gate would raise `irq` with mask bit 7 clear. Random mode writes cover all four ECC codes and every pin bit. A swapped lane, a wrong strobe or an inverted chip enable therefore shows up as a compare mismatch.

// File: rtl/nand_host_pkg.sv
`timescale 1ns/1ps
package nand_host_pkg;
  // configuration page offsets
  localparam logic [7:0] CFG_CMD    = 8'h04;
  localparam logic [7:0] CFG_BASE   = 8'h10;
  // window offsets
  localparam logic [7:0] WIN_MODE   = 8'h04;
  localparam logic [7:0] WIN_STAT   = 8'h05;
  localparam logic [7:0] WIN_ISR    = 8'h06;
  localparam logic [7:0] WIN_IMR    = 8'h07;
  localparam logic [7:0] STAT_VALUE = 8'h14;

  typedef enum logic [1:0] {
    ECC_IDLE  = 2'b00,
    ECC_START = 2'b01,
    ECC_FETCH = 2'b10,
    ECC_CLEAR = 2'b11
  } ecc_cmd_e;

  typedef enum logic [1:0] {
    RGN_NONE = 2'b00,
    RGN_CFG  = 2'b01,
    RGN_WIN  = 2'b10
  } region_e;
endpackage

// File: rtl/nand_host_decode.sv
`timescale 1ns/1ps
module nand_host_decode
  import nand_host_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int CFG_PAGE = 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic              win_enable,
  output region_e           region,
  output logic [7:0]        offset
);
  localparam int PAGE_W = ADDR_W - 8;

  logic [PAGE_W-1:0] page;
  assign page   = addr[ADDR_W-1:8];
  assign offset = addr[7:0];

  always_comb begin
    if (page == '0)
      region = RGN_NONE;
    else if (page == PAGE_W'(CFG_PAGE))
      region = RGN_CFG;
    else if (win_enable && ({page, 8'h00} == base))
      region = RGN_WIN;
    else
      region = RGN_NONE;
  end
endmodule

// File: rtl/nand_host_cfg.sv
`timescale 1ns/1ps
module nand_host_cfg
  import nand_host_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [7:0]        offset,
  input  logic [7:0]        wdata,
  output logic              win_enable,
  output logic [ADDR_W-1:0] base,
  output logic [7:0]        rd_byte
);
  localparam int LANES = ADDR_W / 8;

  always_ff @(posedge clk) begin
    if (rst)
      win_enable <= 1'b0;
    else if (wr_en && offset == CFG_CMD)
      win_enable <= wdata[1];
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)
        base[g*8 +: 8] <= 8'h00;
      else if (wr_en && offset == 8'(CFG_BASE + g))
        base[g*8 +: 8] <= wdata;
    end
  end

  always_comb begin
    rd_byte = 8'h00;
    if (offset == CFG_CMD)
      rd_byte = {6'b0, win_enable, 1'b0};
    for (int i = 0; i < LANES; i++)
      if (offset == 8'(CFG_BASE + i))
        rd_byte = base[i*8 +: 8];
  end

  // R1: enable follows bit 1 of the command byte
  p_cmd_enable_r1: assert property (@(posedge clk) disable iff (rst)
    (wr_en && offset == CFG_CMD) |=> (win_enable == $past(wdata[1])));
endmodule

// File: rtl/nand_host_win.sv
`timescale 1ns/1ps
module nand_host_win
  import nand_host_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] offset,
  input  logic [7:0] wdata,
  output logic       nand_cle,
  output logic       nand_ale,
  output logic       nand_ce_n,
  output logic       nand_wp,
  output logic [7:0] nand_dout,
  output logic       nand_we,
  output logic       nand_re,
  output logic       ecc_clr,
  output logic       ecc_rd,
  output logic       irq,
  output logic       rd_is_data,
  output logic [7:0] rd_byte
);
  logic [7:0] mode_q, isr_q, imr_q;
  logic [7:0] isr_n, imr_n;
  logic       is_data, wr_data, wr_mode;
  ecc_cmd_e   ecc_cmd;

  assign is_data    = (offset[7:2] == 6'd0);
  assign rd_is_data = is_data;
  assign wr_data    = wr_en && is_data;
  assign wr_mode    = wr_en && offset == WIN_MODE;
  assign ecc_cmd    = ecc_cmd_e'(wdata[6:5]);

  always_comb begin
    isr_n = isr_q;
    imr_n = imr_q;
    if (wr_data)
      isr_n = isr_q | 8'h01;
    if (wr_en && offset == WIN_ISR)
      isr_n = wdata;
    if (wr_en && offset == WIN_IMR)
      imr_n = wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= 8'h00;
      isr_q     <= 8'h00;
      imr_q     <= 8'h00;
      irq       <= 1'b0;
      nand_dout <= 8'h00;
      nand_we   <= 1'b0;
      nand_re   <= 1'b0;
      ecc_clr   <= 1'b0;
      ecc_rd    <= 1'b0;
    end else begin
      isr_q   <= isr_n;
      imr_q   <= imr_n;
      irq     <= imr_n[7] && ((imr_n & isr_n) != 8'h00);
      nand_we <= wr_data;
      nand_re <= rd_en && is_data;
      ecc_clr <= wr_mode && (ecc_cmd == ECC_START || ecc_cmd == ECC_CLEAR);
      ecc_rd  <= wr_mode && (ecc_cmd == ECC_FETCH);
      if (wr_mode)
        mode_q <= wdata;
      if (wr_data)
        nand_dout <= wdata;
    end
  end

  assign nand_cle  = mode_q[0];
  assign nand_ale  = mode_q[1];
  assign nand_ce_n = ~mode_q[4];
  assign nand_wp   = mode_q[7];

  always_comb begin
    case (offset)
      WIN_MODE: rd_byte = mode_q;
      WIN_STAT: rd_byte = STAT_VALUE;
      WIN_ISR:  rd_byte = isr_q;
      WIN_IMR:  rd_byte = imr_q;
      default:  rd_byte = 8'h00;
    endcase
  end

  // R4: pins follow the written mode byte
  p_mode_pins_r4: assert property (@(posedge clk) disable iff (rst)
    wr_mode |=> (nand_ce_n == !$past(wdata[4])) && (nand_cle == $past(wdata[0]))
                && (nand_ale == $past(wdata[1])) && (nand_wp == $past(wdata[7])));
  // R5: the two ECC strobes never coincide
  p_ecc_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(ecc_clr && ecc_rd));
  // R6: data write drives the bus and flags status bit 0
  p_data_wr_r6: assert property (@(posedge clk) disable iff (rst)
    wr_data |=> nand_we && isr_q[0] && (nand_dout == $past(wdata)));
  // R10: interrupt needs the global gate and a live source
  p_irq_gate_r10: assert property (@(posedge clk) disable iff (rst)
    irq |-> imr_q[7] && ((imr_q & isr_q) != 8'h00));
endmodule

// File: rtl/nand_host_regs.sv
`timescale 1ns/1ps
module nand_host_regs
  import nand_host_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int CFG_PAGE = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [7:0]        acc_wdata,
  output logic [7:0]        acc_rdata,
  output logic              acc_rvalid,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_ce_n,
  output logic              nand_wp,
  output logic [7:0]        nand_dout,
  output logic              nand_we,
  output logic              nand_re,
  input  logic [7:0]        nand_din,
  output logic              ecc_clr,
  output logic              ecc_rd,
  output logic              irq
);
  region_e           region;
  logic [7:0]        offset;
  logic [ADDR_W-1:0] base;
  logic              win_enable;
  logic [7:0]        cfg_byte, win_byte;
  logic              win_is_data;
  logic              wr_req, rd_req;
  logic              rd_pend_q, rd_nand_q;
  logic [7:0]        rd_hold_q;

  assign wr_req = acc_en && acc_wr;
  assign rd_req = acc_en && !acc_wr;

  nand_host_decode #(.ADDR_W(ADDR_W), .CFG_PAGE(CFG_PAGE)) u_dec (
    .addr(acc_addr), .base(base), .win_enable(win_enable),
    .region(region), .offset(offset));

  nand_host_cfg #(.ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_req && region == RGN_CFG),
    .offset(offset), .wdata(acc_wdata), .win_enable(win_enable),
    .base(base), .rd_byte(cfg_byte));

  nand_host_win u_win (
    .clk(clk), .rst(rst),
    .wr_en(wr_req && region == RGN_WIN), .rd_en(rd_req && region == RGN_WIN),
    .offset(offset), .wdata(acc_wdata),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_ce_n(nand_ce_n),
    .nand_wp(nand_wp), .nand_dout(nand_dout), .nand_we(nand_we),
    .nand_re(nand_re), .ecc_clr(ecc_clr), .ecc_rd(ecc_rd), .irq(irq),
    .rd_is_data(win_is_data), .rd_byte(win_byte));

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pend_q  <= 1'b0;
      rd_nand_q  <= 1'b0;
      rd_hold_q  <= 8'h00;
      acc_rvalid <= 1'b0;
      acc_rdata  <= 8'h00;
    end else begin
      rd_pend_q  <= rd_req;
      rd_nand_q  <= rd_req && region == RGN_WIN && win_is_data;
      case (region)
        RGN_CFG: rd_hold_q <= cfg_byte;
        RGN_WIN: rd_hold_q <= win_byte;
        default: rd_hold_q <= 8'h00;
      endcase
      acc_rvalid <= rd_pend_q;
      if (rd_pend_q)
        acc_rdata <= rd_nand_q ? nand_din : rd_hold_q;
    end
  end

  // R8: status reads return the fixed byte
  p_status_const_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_req && region == RGN_WIN && offset == WIN_STAT) |=> ##1 (acc_rvalid && acc_rdata == 8'h14));
  // R11: each read request produces rvalid two edges later
  p_rvalid_lat_r11: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> ##1 acc_rvalid);
endmodule

// File: tb/nand_host_regs_test.sv
`timescale 1ns/1ps
module nand_host_regs_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_en = 1'b0, acc_wr = 1'b0;
  logic [31:0] acc_addr = '0;
  logic [7:0]  acc_wdata = '0, nand_din = '0;
  logic [7:0]  acc_rdata, nand_dout;
  logic        acc_rvalid, nand_cle, nand_ale, nand_ce_n, nand_wp;
  logic        nand_we, nand_re, ecc_clr, ecc_rd, irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  nand_host_regs uut (.*);

  localparam logic [31:0] CFG = 32'h0000_0100;
  localparam logic [31:0] WB  = 32'h0002_3400;

  logic [7:0] m_mode, m_isr, m_imr;
  logic       rd_v, rd_re;
  logic [7:0] rd_d;

  function automatic logic exp_irq(input logic [7:0] imr, input logic [7:0] isr);
    return imr[7] && ((imr & isr) != 8'h00);
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [7:0] d);
    @(negedge clk);
    acc_en = 1; acc_wr = 1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_en = 0; acc_wr = 0;
  endtask

  task automatic rd(input logic [31:0] a);
    @(negedge clk);
    acc_en = 1; acc_wr = 0; acc_addr = a;
    @(negedge clk);
    acc_en = 0;
    rd_re = nand_re;
    @(negedge clk);
    rd_v = acc_rvalid; rd_d = acc_rdata;
  endtask

  task automatic chk_pins(input string tag);
    chk({tag, " R4 cle"},  nand_cle,  m_mode[0]);
    chk({tag, " R4 ale"},  nand_ale,  m_mode[1]);
    chk({tag, " R4 ce_n"}, nand_ce_n, !m_mode[4]);
    chk({tag, " R4 wp"},   nand_wp,   m_mode[7]);
    chk({tag, " R10 irq"}, irq,       exp_irq(m_imr, m_isr));
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    m_mode = 0; m_isr = 0; m_imr = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    chk_pins("reset");
    rd(CFG + 32'h04); chk("R1 enable reset readback", rd_d, 8'h00);
    chk("R11 rvalid", rd_v, 1'b1);
    rd(CFG + 32'h13); chk("R2 base reset", rd_d, 8'h00);

    // base with nonzero low byte: window must stay dead (R3)
    wr(CFG + 32'h10, 8'h01); wr(CFG + 32'h11, 8'h34);
    wr(CFG + 32'h12, 8'h02); wr(CFG + 32'h13, 8'h00);
    rd(CFG + 32'h11); chk("R2 lane1", rd_d, 8'h34);
    rd(CFG + 32'h10); chk("R2 lane0", rd_d, 8'h01);
    // disabled window
    wr(WB + 32'h04, 8'h10); chk("R3 disabled write ignored ce_n", nand_ce_n, 1'b1);
    wr(CFG + 32'h04, 8'hFD); rd(CFG + 32'h04); chk("R1 bit1 clear keeps disabled", rd_d, 8'h00);
    wr(CFG + 32'h04, 8'h02); rd(CFG + 32'h04); chk("R1 enable readback", rd_d, 8'h02);
    wr(WB + 32'h04, 8'h10); chk("R3 low-byte base mismatch ce_n", nand_ce_n, 1'b1);
    rd(WB + 32'h05); chk("R3 dead window reads 0", rd_d, 8'h00);
    wr(CFG + 32'h10, 8'h00);
    rd(WB + 32'h05); chk("R8 status", rd_d, 8'h14);
    chk("R11 rvalid window", rd_v, 1'b1);
    // page 0 never decodes as window
    wr(32'h0000_0004, 8'h10); chk("R3 page0 ignored", nand_ce_n, 1'b1);

    // directed irq gating (R10, R9, R6)
    wr(WB + 32'h07, 8'h01); m_imr = 8'h01;
    wr(WB + 32'h06, 8'h40); m_isr = 8'h40;
    wr(WB + 32'h02, 8'hA5); m_isr = 8'h41;
    chk("R6 we", nand_we, 1'b1); chk("R6 dout", nand_dout, 8'hA5);
    chk("R10 no gate no irq", irq, 1'b0);
    rd(WB + 32'h06); chk("R6 isr keeps others", rd_d, 8'h41);
    wr(WB + 32'h07, 8'h81); m_imr = 8'h81; chk("R10 irq set", irq, 1'b1);
    wr(WB + 32'h06, 8'h00); m_isr = 8'h00; chk("R9 isr replace irq drop", irq, 1'b0);
    rd(WB + 32'h09); chk("R9 unmapped reads 0", rd_d, 8'h00);

    for (int k = 0; k < 400; k++) begin
      int unsigned op = $urandom % 6;
      logic [7:0] d = 8'($urandom);
      logic [7:0] o;
      case (op)
        0: begin
          wr(WB + 32'h04, d); m_mode = d;
          chk("R5 ecc_clr", ecc_clr, (d[6:5] == 2'b01) || (d[6:5] == 2'b11));
          chk("R5 ecc_rd",  ecc_rd,  d[6:5] == 2'b10);
          chk_pins("rand mode");
        end
        1: begin wr(WB + 32'h06, d); m_isr = d; chk_pins("rand isr R9"); end
        2: begin wr(WB + 32'h07, d); m_imr = d; chk_pins("rand imr R9"); end
        3: begin
          o = 8'($urandom % 4);
          wr(WB + 32'(o), d); m_isr = m_isr | 8'h01;
          chk("R6 we", nand_we, 1'b1); chk("R6 dout", nand_dout, d);
          chk_pins("rand data");
        end
        4: begin
          o = 8'($urandom % 4);
          nand_din = d;
          rd(WB + 32'(o));
          chk("R7 re", rd_re, 1'b1); chk("R7 rdata", rd_d, d); chk("R11 rvalid", rd_v, 1'b1);
        end
        default: begin
          o = 8'(4 + $urandom % 4);
          rd(WB + 32'(o));
          chk("R7 no re", rd_re, 1'b0);
          case (o)
            8'h04: chk("R4 mode readback", rd_d, m_mode);
            8'h05: chk("R8 status", rd_d, 8'h14);
            8'h06: chk("R9 isr readback", rd_d, m_isr);
            default: chk("R9 imr readback", rd_d, m_imr);
          endcase
        end
      endcase
    end

    // disable again: writes ignored, reads zero (R3)
    wr(CFG + 32'h04, 8'h00);
    wr(WB + 32'h04, ~m_mode);
    chk_pins("R3 after disable");
    rd(WB + 32'h07); chk("R3 disabled read", rd_d, 8'h00);
    @(negedge clk); chk("R11 rvalid single pulse", acc_rvalid, 1'b0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule